// File: doc/BRIEF.md
# DMA Controller Command and Mask Unit

This block decodes the eight byte-wide control offsets of a four-channel DMA controller and owns the state that the channel service logic reads. That state is a command register, an eight-bit channel mask, an eight-bit status register, a byte-pointer flip-flop and one mode byte per channel. The status register holds a terminal-count bit for each channel in its low half and a pending-request bit for each channel in its high half. The request bit can be driven both by software through a control write and by external request set and release pulses.

The service logic watches the mask, request and mode outputs. It also watches a one-cycle re-evaluate strobe, which fires whenever the mask or the request state may have changed. A companion channel-register decoder toggles the byte-pointer flip-flop through a dedicated input. The service logic reports a finished channel through a terminal-count pulse. Register reads are registered, and the byte appears on `rdata_o` in the cycle after the read strobe.

Top module: `dmac_ctl_unit`

## Requirements
- R1: A write at offset 0 loads the command register only when the byte is 0x00 or 0x04. Any other byte, meaning one with a bit other than bit 2 set, leaves the command register unchanged.
- R2: A write at offset 1 takes the channel from bits [1:0] and writes bit 2 into that channel's request bit, which is status bit 4+channel. The same write clears that channel's terminal-count bit, which is status bit channel.
- R3: A write at offset 2 takes the channel from bits [1:0] and writes bit 2 into mask bit channel, where 1 means masked. The other mask bits keep their values.
- R4: A write at offset 6 clears all eight mask bits. A write at offset 7 loads the mask with the written byte.
- R5: A write at offset 3 stores the whole byte as the mode of the channel named by bits [1:0]. Channel c's mode appears on `mode_o[8c+7:8c]`.
- R6: A one-cycle pulse on `bp_toggle_i` inverts the byte-pointer flip-flop. A write at offset 4 clears it, and the clear wins over a toggle in the same cycle.
- R7: A write at offset 5 clears the flip-flop, status and command, and sets the mask to 0xFF. The mode bytes are left unchanged.
- R8: A read at offset 0 returns the status byte on `rdata_o` in the next cycle. It then clears status bits [3:0] and keeps bits [7:4].
- R9: A read at offset 1 returns the mask byte. A read at any offset from 2 to 7 returns 0x00.
- R10: A pulse on `dreq_set_i[c]` sets status bit 4+c, and a pulse on `dreq_clr_i[c]` clears it. Either pulse wins over an offset-1 write to the same channel in the same cycle.
- R11: A pulse on `tc_set_i[c]` sets status bit c. It wins over a status-read clear in the same cycle.
- R12: `reeval_o` is high for exactly the one cycle after an offset 1, 2, 6 or 7 write, or after any external request pulse. It stays low after command, mode, flip-flop-clear and master-reset writes.
- R13: The `rst` input has the same effect as an offset-5 write, and it also clears every mode byte to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Control write strobe |
| rd_en_i | input | 1 | Control read strobe |
| addr_i | input | 3 | Control offset |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Registered read byte |
| dreq_set_i | input | 4 | Per-channel external request assert pulse |
| dreq_clr_i | input | 4 | Per-channel external request release pulse |
| tc_set_i | input | 4 | Per-channel terminal-count pulse from the service logic |
| bp_toggle_i | input | 1 | Byte-pointer toggle from the channel register decoder |
| command_o | output | 8 | Command register |
| mask_o | output | 8 | Mask register |
| req_o | output | 4 | Pending request bits (status [7:4]) |
| mode_o | output | 32 | Mode bytes, channel c at [8c+7:8c] |
| bp_ff_o | output | 1 | Byte-pointer flip-flop |
| reeval_o | output | 1 | One-cycle re-evaluate strobe |

## Verification
The hardest cases are the cycles where two sources update the same status bit at once. One is a terminal-count pulse that lands on the same edge as the status read that clears it. The other is an external request pulse that coincides with a software request write to the same channel. The bench reaches these cases by driving the sideband pulses inside the same cycle as the register strobe. It then reads the status back, so the read shows whether the old byte came out and which source won.

// File: rtl/dmac_ctl_pkg.sv
package dmac_ctl_pkg;
  typedef enum logic [2:0] {
    OFS_CMD     = 3'd0,
    OFS_REQ     = 3'd1,
    OFS_SMASK   = 3'd2,
    OFS_MODE    = 3'd3,
    OFS_FFCLR   = 3'd4,
    OFS_MCLR    = 3'd5,
    OFS_UNMASK  = 3'd6,
    OFS_MASKALL = 3'd7
  } ctl_ofs_e;

  // only the block-control bit of the command byte is supported
  localparam logic [7:0] CMD_KEEP_BITS = 8'h04;
  // bit of a request / single-mask write that carries the new value
  localparam int VAL_BIT = 2;

  function automatic logic cmd_ok(input logic [7:0] v);
    return (v & ~CMD_KEEP_BITS) == 8'h00;
  endfunction
endpackage

// File: rtl/dmac_cmd_reg.sv
module dmac_cmd_reg
  import dmac_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              master_clr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cmd_q
);
  always_ff @(posedge clk) begin
    if (master_clr)
      cmd_q <= '0;
    else if (wr && cmd_ok(wdata))
      cmd_q <= wdata;
  end

  assert_cmd_drop_R1: assert property (@(posedge clk) disable iff (master_clr)
    (wr && !cmd_ok(wdata)) |=> $stable(cmd_q));
endmodule

// File: rtl/dmac_mask_reg.sv
module dmac_mask_reg
  import dmac_ctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NCH    = 4
) (
  input  logic              clk,
  input  logic              master_clr,
  input  logic              wr_single,
  input  logic              wr_clear,
  input  logic              wr_all,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_q
);
  localparam int CW = $clog2(NCH);

  logic [CW-1:0] sel;
  assign sel = wdata[CW-1:0];

  always_ff @(posedge clk) begin
    if (master_clr)
      mask_q <= '1;
    else if (wr_all)
      mask_q <= wdata;
    else if (wr_clear)
      mask_q <= '0;
    else if (wr_single)
      mask_q[sel] <= wdata[VAL_BIT];
  end

  assert_single_mask_R3: assert property (@(posedge clk) disable iff (master_clr)
    wr_single |=> (mask_q[$past(sel)] == $past(wdata[VAL_BIT])));
  assert_clear_all_R4: assert property (@(posedge clk) disable iff (master_clr)
    (wr_clear && !wr_all) |=> (mask_q == '0));
endmodule

// File: rtl/dmac_status_reg.sv
module dmac_status_reg
  import dmac_ctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NCH    = 4
) (
  input  logic              clk,
  input  logic              master_clr,
  input  logic              rd_clr,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NCH-1:0]    dreq_set,
  input  logic [NCH-1:0]    dreq_clr,
  input  logic [NCH-1:0]    tc_set,
  output logic [2*NCH-1:0]  stat_q
);
  localparam int CW = $clog2(NCH);
  localparam int SW = 2 * NCH;

  logic [SW-1:0] stat_d;
  logic [CW-1:0] sel;
  assign sel = wdata[CW-1:0];

  always_comb begin
    stat_d = stat_q;
    if (rd_clr)
      stat_d[NCH-1:0] = '0;
    if (wr_req) begin
      stat_d[NCH + 32'(sel)] = wdata[VAL_BIT];
      stat_d[sel]            = 1'b0;
    end
    for (int c = 0; c < NCH; c++) begin
      if (dreq_set[c])
        stat_d[NCH+c] = 1'b1;
      else if (dreq_clr[c])
        stat_d[NCH+c] = 1'b0;
      if (tc_set[c])
        stat_d[c] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (master_clr)
      stat_q <= '0;
    else
      stat_q <= stat_d;
  end

  assert_rd_clr_R8: assert property (@(posedge clk) disable iff (master_clr)
    (rd_clr && (tc_set == '0)) |=> (stat_q[NCH-1:0] == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_dreq_set_R10: assert property (@(posedge clk) disable iff (master_clr)
      dreq_set[c] |=> stat_q[NCH+c]);
    assert_dreq_clr_R10: assert property (@(posedge clk) disable iff (master_clr)
      (dreq_clr[c] && !dreq_set[c]) |=> !stat_q[NCH+c]);
    assert_tc_set_R11: assert property (@(posedge clk) disable iff (master_clr)
      tc_set[c] |=> stat_q[c]);
  end
endmodule

// File: rtl/dmac_mode_bank.sv
module dmac_mode_bank #(
  parameter int DATA_W = 8,
  parameter int NCH    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [NCH*DATA_W-1:0] mode_flat
);
  localparam int CW = $clog2(NCH);

  logic [DATA_W-1:0] mode_q [NCH];
  logic [CW-1:0]     sel;
  assign sel = wdata[CW-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)
        mode_q[c] <= '0;
      else if (wr && (sel == CW'(c)))
        mode_q[c] <= wdata;
    end
    assign mode_flat[c*DATA_W +: DATA_W] = mode_q[c];
  end

  assert_mode_store_R5: assert property (@(posedge clk) disable iff (rst)
    wr |=> (mode_q[$past(sel)] == $past(wdata)));
endmodule

// File: rtl/dmac_ctl_unit.sv
module dmac_ctl_unit
  import dmac_ctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NCH    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [2:0]            addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [NCH-1:0]        dreq_set_i,
  input  logic [NCH-1:0]        dreq_clr_i,
  input  logic [NCH-1:0]        tc_set_i,
  input  logic                  bp_toggle_i,
  output logic [DATA_W-1:0]     command_o,
  output logic [DATA_W-1:0]     mask_o,
  output logic [NCH-1:0]        req_o,
  output logic [NCH*DATA_W-1:0] mode_o,
  output logic                  bp_ff_o,
  output logic                  reeval_o
);
  localparam int SW = 2 * NCH;

  logic wr_cmd, wr_req, wr_smask, wr_mode, wr_ffclr, wr_mclr, wr_unmask, wr_maskall;
  logic rd_stat, rd_mask, master_clr, reeval_evt;
  logic [SW-1:0] stat_q;

  assign wr_cmd     = wr_en_i && (addr_i == OFS_CMD);
  assign wr_req     = wr_en_i && (addr_i == OFS_REQ);
  assign wr_smask   = wr_en_i && (addr_i == OFS_SMASK);
  assign wr_mode    = wr_en_i && (addr_i == OFS_MODE);
  assign wr_ffclr   = wr_en_i && (addr_i == OFS_FFCLR);
  assign wr_mclr    = wr_en_i && (addr_i == OFS_MCLR);
  assign wr_unmask  = wr_en_i && (addr_i == OFS_UNMASK);
  assign wr_maskall = wr_en_i && (addr_i == OFS_MASKALL);
  assign rd_stat    = rd_en_i && (addr_i == OFS_CMD);
  assign rd_mask    = rd_en_i && (addr_i == OFS_REQ);

  assign master_clr = rst || wr_mclr;
  assign reeval_evt = wr_req || wr_smask || wr_unmask || wr_maskall ||
                      (dreq_set_i != '0) || (dreq_clr_i != '0);

  dmac_cmd_reg #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .master_clr(master_clr), .wr(wr_cmd), .wdata(wdata_i),
    .cmd_q(command_o));

  dmac_mask_reg #(.DATA_W(DATA_W), .NCH(NCH)) u_mask (
    .clk(clk), .master_clr(master_clr), .wr_single(wr_smask),
    .wr_clear(wr_unmask), .wr_all(wr_maskall), .wdata(wdata_i),
    .mask_q(mask_o));

  dmac_status_reg #(.DATA_W(DATA_W), .NCH(NCH)) u_stat (
    .clk(clk), .master_clr(master_clr), .rd_clr(rd_stat), .wr_req(wr_req),
    .wdata(wdata_i), .dreq_set(dreq_set_i), .dreq_clr(dreq_clr_i),
    .tc_set(tc_set_i), .stat_q(stat_q));

  dmac_mode_bank #(.DATA_W(DATA_W), .NCH(NCH)) u_mode (
    .clk(clk), .rst(rst), .wr(wr_mode), .wdata(wdata_i), .mode_flat(mode_o));

  assign req_o = stat_q[SW-1:NCH];

  always_ff @(posedge clk) begin
    if (master_clr || wr_ffclr)
      bp_ff_o <= 1'b0;
    else if (bp_toggle_i)
      bp_ff_o <= ~bp_ff_o;
  end

  always_ff @(posedge clk) begin
    if (rst)
      reeval_o <= 1'b0;
    else
      reeval_o <= reeval_evt;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_o <= '0;
    else if (rd_en_i) begin
      if (rd_stat)
        rdata_o <= DATA_W'(stat_q);
      else if (rd_mask)
        rdata_o <= mask_o;
      else
        rdata_o <= '0;
    end
  end

  assert_mclr_R7: assert property (@(posedge clk) disable iff (rst)
    wr_mclr |=> ((mask_o == '1) && (command_o == '0) && !bp_ff_o && (stat_q == '0)));
  assert_ff_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    (bp_toggle_i && !wr_ffclr && !wr_mclr) |=> (bp_ff_o != $past(bp_ff_o)));
  assert_reeval_hi_R12: assert property (@(posedge clk) disable iff (rst)
    reeval_evt |=> reeval_o);
  assert_reeval_lo_R12: assert property (@(posedge clk) disable iff (rst)
    !reeval_evt |=> !reeval_o);
endmodule

// File: tb/sim_dmac_ctl_unit.sv
module sim_dmac_ctl_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en, bp_tog;
  logic [2:0]  addr;
  logic [7:0]  wdata, rdata, command, mask;
  logic [3:0]  dset, dclr, tcs, req;
  logic [31:0] mode;
  logic        bp_ff, reeval;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  dmac_ctl_unit u0 (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .dreq_set_i(dset), .dreq_clr_i(dclr),
    .tc_set_i(tcs), .bp_toggle_i(bp_tog), .command_o(command), .mask_o(mask),
    .req_o(req), .mode_o(mode), .bp_ff_o(bp_ff), .reeval_o(reeval));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    dset = '0; dclr = '0; tcs = '0; bp_tog = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); idle();
  endtask

  task automatic side(input logic [3:0] s, input logic [3:0] c, input logic [3:0] t, input logic g);
    @(negedge clk); dset = s; dclr = c; tcs = t; bp_tog = g;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    chk("R13 mask", mask, 8'hFF);
    chk("R13 command", command, 0);
    chk("R13 ff", bp_ff, 0);
    chk("R13 req", req, 0);
    chk("R13 mode", mode, 0);
    chk("R12 idle reeval", reeval, 0);
    rd(3'd0); chk("R8 status after reset", rdata, 0);
    rd(3'd1); chk("R9 mask read", rdata, 8'hFF);
  endtask

  task automatic t_command();
    wr(3'd0, 8'h04); chk("R1 accept 04", command, 8'h04);
    chk("R12 no reeval on command", reeval, 0);
    wr(3'd0, 8'h10); chk("R1 drop 10", command, 8'h04);
    wr(3'd0, 8'h00); chk("R1 accept 00", command, 8'h00);
    wr(3'd0, 8'h84); chk("R1 drop 84", command, 8'h00);
  endtask

  task automatic t_mask();
    wr(3'd2, 8'h02); chk("R3 unmask ch2", mask, 8'hFB);
    chk("R12 reeval single mask", reeval, 1);
    @(negedge clk); chk("R12 reeval one cycle", reeval, 0);
    wr(3'd2, 8'h06); chk("R3 mask ch2", mask, 8'hFF);
    wr(3'd7, 8'h5A); chk("R4 write all", mask, 8'h5A);
    chk("R12 reeval write all", reeval, 1);
    wr(3'd6, 8'hFF); chk("R4 clear all", mask, 8'h00);
    chk("R12 reeval clear all", reeval, 1);
    rd(3'd1); chk("R9 mask read 00", rdata, 8'h00);
    wr(3'd7, 8'hA5);
    rd(3'd1); chk("R9 mask read A5", rdata, 8'hA5);
    rd(3'd3); chk("R9 offset3 reads 0", rdata, 0);
    rd(3'd7); chk("R9 offset7 reads 0", rdata, 0);
  endtask

  task automatic t_mode();
    wr(3'd3, 8'h95); chk("R12 no reeval on mode", reeval, 0);
    wr(3'd3, 8'h4B);
    chk("R5 mode layout", mode, 32'h4B00_9500);
  endtask

  task automatic t_ff();
    side('0, '0, '0, 1); chk("R6 toggle 1", bp_ff, 1);
    side('0, '0, '0, 1); chk("R6 toggle 0", bp_ff, 0);
    side('0, '0, '0, 1);
    wr(3'd4, 8'h00); chk("R6 clear", bp_ff, 0);
    chk("R12 no reeval on ff clear", reeval, 0);
    side('0, '0, '0, 1);
    @(negedge clk); wr_en = 1; addr = 3'd4; bp_tog = 1;
    @(negedge clk); idle(); chk("R6 clear beats toggle", bp_ff, 0);
  endtask

  task automatic t_request();
    wr(3'd1, 8'h06); chk("R2 set req ch2", req, 4'b0100);
    chk("R12 reeval request", reeval, 1);
    side('0, '0, 4'b0100, 0);
    chk("R11 no reeval on tc", reeval, 0);
    rd(3'd0); chk("R11 tc ch2 set", rdata, 8'h44);
    wr(3'd1, 8'h02); chk("R2 clear req ch2", req, 0);
    rd(3'd0); chk("R2 status cleared", rdata, 8'h00);
    side('0, '0, 4'b0100, 0);
    wr(3'd1, 8'h06);
    rd(3'd0); chk("R2 write clears tc", rdata, 8'h40);
    wr(3'd1, 8'h02);
    wr(3'd1, 8'h04); side('0, '0, 4'b1000, 0);
    rd(3'd0); chk("R8 read status", rdata, 8'h18);
    rd(3'd0); chk("R8 low half cleared", rdata, 8'h10);
    @(negedge clk); rd_en = 1; addr = 3'd0; tcs = 4'b0001;
    @(negedge clk); idle(); chk("R11 read returns old", rdata, 8'h10);
    rd(3'd0); chk("R11 tc beats read clear", rdata, 8'h11);
  endtask

  task automatic t_dreq();
    side(4'b0010, '0, '0, 0); chk("R10 dreq set", req, 4'b0011);
    chk("R12 reeval dreq", reeval, 1);
    side('0, 4'b0010, '0, 0); chk("R10 dreq release", req, 4'b0001);
    chk("R12 reeval release", reeval, 1);
    @(negedge clk); wr_en = 1; addr = 3'd1; wdata = 8'h07; dclr = 4'b1000;
    @(negedge clk); idle(); chk("R10 release beats write", req, 4'b0001);
    @(negedge clk); wr_en = 1; addr = 3'd1; wdata = 8'h03; dset = 4'b1000;
    @(negedge clk); idle(); chk("R10 set beats write", req, 4'b1001);
  endtask

  task automatic t_master();
    wr(3'd0, 8'h04); wr(3'd6, 8'h00); side('0, '0, '0, 1);
    side('0, '0, 4'b0010, 0);
    wr(3'd5, 8'h00);
    chk("R7 command", command, 0);
    chk("R7 mask", mask, 8'hFF);
    chk("R7 ff", bp_ff, 0);
    chk("R7 req", req, 0);
    chk("R7 modes kept", mode, 32'h4B00_9500);
    chk("R12 no reeval on master reset", reeval, 0);
    rd(3'd0); chk("R7 status", rdata, 0);
  endtask

  task automatic t_rst();
    wr(3'd0, 8'h04); wr(3'd6, 8'h00); side(4'b0100, '0, '0, 1);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R13 modes zero", mode, 0);
    chk("R13 mask", mask, 8'hFF);
    chk("R13 command", command, 0);
    chk("R13 req", req, 0);
    chk("R13 ff", bp_ff, 0);
  endtask

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_command();
    t_mask();
    t_mode();
    t_ff();
    t_request();
    t_dreq();
    t_master();
    t_rst();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule